// File: doc/BRIEF.md
# Page-Bounded Stream Prefetcher

This block sits beside a cache controller and watches the line addresses of its demand accesses. It remembers a short history for each of the sixteen 4 KiB pages touched most recently. From that history it spots simple ascending or descending walks inside a page and queues prefetch requests for the next one or two lines along the walk. A prefetch never leaves the page of the access that caused it. Each request carries a fill-target hint. The hint always means "fill the last-level cache". It also means "fill the mid-level cache" unless that cache reported heavy demand load when the request was made.

A page is tracked as a 16-entry table with least-recently-used replacement. Each entry holds the page tag, the last line offset seen, and two stream records, one for the upward walk and one for the downward walk. Each record has an active flag and a frontier, which is the furthest line already requested in that direction. Candidates go into a 4-entry request queue with a valid/ready handshake. When the queue has no room, a candidate is dropped and demand tracking keeps going.

A small control machine has two named states. ST_OFF means disabled: the table and the queue are held empty and accesses are ignored. ST_RUN means tracking. The machine moves ST_OFF to ST_RUN on the clock edge that sees `en` high, and ST_RUN to ST_OFF on the edge that sees `en` low. Each accepted access is given one of four classes: CLS_NEW (page not tracked), CLS_SAME (same line as before), CLS_FWD (higher offset) or CLS_BWD (lower offset).

Top module: `page_stream_prefetcher`

## Requirements
- R1: After reset, `pf_valid` is low, every page is untracked and the control state is ST_OFF.
- R2: An accepted access to an untracked page allocates a table entry and queues no request.
- R3: An access to a tracked page at a higher line offset than the last one queues offset+1 if the upward record was inactive (confirm), and queues offset+1 then offset+2 if it was active (extend). Upward candidates that are not above the upward frontier are skipped.
- R4: An access at a lower offset is handled the same way in the downward direction with offset-1 and offset-2. Downward candidates that are not below the downward frontier are skipped.
- R5: Line offset is bits [5:0] of `dmd_line` (64 lines per page). The page is the bits above it. Candidates above offset 63 or below offset 0 are dropped, so a request always shares the page of its trigger.
- R6: A repeated access to the last line of a tracked page queues nothing and leaves the streams unchanged.
- R7: A line that a stream has already requested, meaning it is at or behind the frontier, is never requested again by that stream.
- R8: The table keeps the 16 most recently accessed pages. A page that sees 16 other distinct pages accessed after its last use is forgotten, and its next access counts as new. A permutation over 17 or more pages therefore produces no requests.
- R9: `pf_mlc` is 1 (fill mid-level and last-level) when `mlc_busy` was low in the triggering access cycle. It is 0 (last-level only) when `mlc_busy` was high.
- R10: The queue holds 4 requests. The head stays stable while `pf_ready` is low. A candidate is accepted only while the queue count from before this cycle's pop, plus candidates already accepted this cycle, is below 4. The first candidate is tried first.
- R11: While `en` is low, accesses are ignored and the table and queue are cleared. `pf_valid` is low from the cycle after `en` falls. Tracking resumes one cycle after `en` rises.
- R12: A request triggered by an access sampled at clock edge k reaches the head of an empty queue and raises `pf_valid` right after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low clears and idles the block |
| dmd_valid | input | 1 | Demand access present this cycle |
| dmd_line | input | ADDR_W-6 | Line address of the demand access |
| mlc_busy | input | 1 | Mid-level cache under heavy demand load |
| pf_valid | output | 1 | Prefetch request at queue head |
| pf_ready | input | 1 | Consumer accepts the head request |
| pf_line | output | ADDR_W-6 | Line address to prefetch |
| pf_mlc | output | 1 | 1: fill mid-level and last-level; 0: last-level only |

## Verification
Almost every internal fault shows up in the request stream one cycle after the access that exposes it. A stale frontier appears as a duplicate or missing line. A bad replacement order shows up when a revisited page does or does not prefetch. A wrong queue pointer shows up as reordered or lost lines at the head. The bench keeps its own page history and request queue and compares `pf_valid`, `pf_line` and `pf_mlc` on every clock. Faults in eviction need a 16- or 17-page walk before they appear, which takes a few dozen cycles.

// File: rtl/pf_stream_pkg.sv
package pf_stream_pkg;
    localparam int LINE_BYTES = 64;
    localparam int PAGE_BYTES = 4096;
    localparam int LINE_SH    = $clog2(LINE_BYTES);
    localparam int PAGE_SH    = $clog2(PAGE_BYTES);
    localparam int OFF_W      = PAGE_SH - LINE_SH;

    typedef logic [OFF_W-1:0] off_t;

    // Per-page stream history
    typedef struct packed {
        off_t last;
        logic up_on;
        logic dn_on;
        off_t up_edge;
        off_t dn_edge;
    } strm_t;

    typedef enum logic [1:0] {CLS_NEW, CLS_SAME, CLS_FWD, CLS_BWD} acc_cls_e;
    typedef enum logic {ST_OFF, ST_RUN} ctl_state_e;
endpackage

// File: rtl/pf_stream_calc.sv
module pf_stream_calc
    import pf_stream_pkg::*;
(
    input  logic     hit,
    input  strm_t    old_st,
    input  off_t     off,
    output acc_cls_e cls,
    output strm_t    new_st,
    output logic [1:0] cand_v,
    output off_t     cand_off [2]
);
    logic [OFF_W:0] up1, up2;
    off_t up1_cap, up2_cap, dn1, dn2, reach;

    assign up1     = {1'b0, off} + (OFF_W+1)'(1);
    assign up2     = {1'b0, off} + (OFF_W+1)'(2);
    assign up1_cap = up1[OFF_W] ? '1 : up1[OFF_W-1:0];
    assign up2_cap = up2[OFF_W] ? '1 : up2[OFF_W-1:0];
    assign dn1     = off - off_t'(1);
    assign dn2     = off - off_t'(2);

    always_comb begin
        cls         = CLS_NEW;
        new_st      = old_st;
        cand_v      = 2'b00;
        cand_off[0] = up1[OFF_W-1:0];
        cand_off[1] = up2[OFF_W-1:0];
        reach       = '0;
        if (!hit) begin
            cls         = CLS_NEW;
            new_st      = '0;
            new_st.last = off;
        end else if (off == old_st.last) begin
            cls = CLS_SAME;
        end else if (off > old_st.last) begin
            cls       = CLS_FWD;
            cand_v[0] = !up1[OFF_W] && (!old_st.up_on || up1[OFF_W-1:0] > old_st.up_edge);
            cand_v[1] = old_st.up_on && !up2[OFF_W] && (up2[OFF_W-1:0] > old_st.up_edge);
            reach     = old_st.up_on ? up2_cap : up1_cap;
            new_st.up_edge = (old_st.up_on && old_st.up_edge > reach) ? old_st.up_edge : reach;
            new_st.up_on   = 1'b1;
            new_st.last    = off;
        end else begin
            cls         = CLS_BWD;
            cand_off[0] = dn1;
            cand_off[1] = dn2;
            cand_v[0]   = (off != '0) && (!old_st.dn_on || dn1 < old_st.dn_edge);
            cand_v[1]   = old_st.dn_on && (off > off_t'(1)) && (dn2 < old_st.dn_edge);
            if (old_st.dn_on) reach = (off > off_t'(1)) ? dn2 : '0;
            else              reach = (off != '0) ? dn1 : '0;
            new_st.dn_edge = (old_st.dn_on && old_st.dn_edge < reach) ? old_st.dn_edge : reach;
            new_st.dn_on   = 1'b1;
            new_st.last    = off;
        end
    end
endmodule

// File: rtl/pf_page_table.sv
module pf_page_table
    import pf_stream_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic [TAG_W-1:0] tag_in,
    input  strm_t            st_in,
    output logic             hit,
    output strm_t            st_out
);
    logic             vld  [ENTRIES];
    logic [TAG_W-1:0] tag  [ENTRIES];
    strm_t            st   [ENTRIES];
    logic [IDX_W-1:0] rank [ENTRIES];   // 0 = most recent
    logic [IDX_W-1:0] hit_idx, vic_idx, sel, sel_rank;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        vic_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld[i] && tag[i] == tag_in) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (rank[i] == IDX_W'(ENTRIES-1)) vic_idx = IDX_W'(i);
        end
    end

    assign sel      = hit ? hit_idx : vic_idx;
    assign sel_rank = rank[sel];
    assign st_out   = st[hit_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld[i]  <= 1'b0;
                tag[i]  <= '0;
                st[i]   <= '0;
                rank[i] <= IDX_W'(i);
            end
        end else if (clr) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld[i]  <= 1'b0;
                rank[i] <= IDX_W'(i);
            end
        end else if (upd) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == sel) begin
                    vld[i]  <= 1'b1;
                    tag[i]  <= tag_in;
                    st[i]   <= st_in;
                    rank[i] <= '0;
                end else if (rank[i] < sel_rank) begin
                    rank[i] <= rank[i] + IDX_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pf_req_fifo.sv
module pf_req_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 27,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       push_v,
    input  logic [W-1:0]     push_d [2],
    input  logic             pop,
    output logic             nonempty,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             acc0, acc1;
    logic [CNT_W-1:0] after0;

    assign acc0     = push_v[0] && (count < CNT_W'(DEPTH));
    assign after0   = count + CNT_W'(acc0);
    assign acc1     = push_v[1] && (after0 < CNT_W'(DEPTH));
    assign nonempty = (count != '0);
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (acc0) mem[wr_ptr] <= push_d[0];
            if (acc1) mem[wr_ptr + PTR_W'(acc0)] <= push_d[1];
            wr_ptr <= wr_ptr + PTR_W'(acc0) + PTR_W'(acc1);
            if (pop) rd_ptr <= rd_ptr + PTR_W'(1);
            count  <= count + CNT_W'(acc0) + CNT_W'(acc1) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/page_stream_prefetcher.sv
module page_stream_prefetcher
    import pf_stream_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 16,
    parameter int FIFO_DEPTH = 4,
    localparam int LINE_W    = ADDR_W - LINE_SH,
    localparam int TAG_W     = LINE_W - OFF_W,
    localparam int CNT_W     = $clog2(FIFO_DEPTH+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dmd_valid,
    input  logic [LINE_W-1:0] dmd_line,
    input  logic              mlc_busy,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [LINE_W-1:0] pf_line,
    output logic              pf_mlc
);
    ctl_state_e       state, state_nxt;
    logic             run, acc_fire, pop;
    logic [TAG_W-1:0] acc_tag;
    off_t             acc_off;
    logic             tbl_hit;
    strm_t            tbl_old, tbl_new;
    acc_cls_e         acc_cls;
    logic [1:0]       cand_v, push_v;
    off_t             cand_off [2];
    logic [LINE_W:0]  push_d [2];
    logic             fifo_ne;
    logic [LINE_W:0]  fifo_head;
    logic [CNT_W-1:0] fifo_cnt;

    // control state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: if (en)  state_nxt = ST_RUN;
            ST_RUN: if (!en) state_nxt = ST_OFF;
            default:         state_nxt = ST_OFF;
        endcase
    end

    // outputs of the control machine
    always_comb begin
        run      = (state == ST_RUN);
        acc_fire = run && en && dmd_valid;
        pf_valid = run && fifo_ne;
        pop      = pf_valid && pf_ready;
        push_v   = acc_fire ? cand_v : 2'b00;
    end

    assign acc_tag = dmd_line[LINE_W-1:OFF_W];
    assign acc_off = dmd_line[OFF_W-1:0];

    pf_page_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!en),
        .upd    (acc_fire),
        .tag_in (acc_tag),
        .st_in  (tbl_new),
        .hit    (tbl_hit),
        .st_out (tbl_old)
    );

    pf_stream_calc u_calc (
        .hit      (tbl_hit),
        .old_st   (tbl_old),
        .off      (acc_off),
        .cls      (acc_cls),
        .new_st   (tbl_new),
        .cand_v   (cand_v),
        .cand_off (cand_off)
    );

    for (genvar k = 0; k < 2; k++) begin : g_lane
        assign push_d[k] = {~mlc_busy, acc_tag, cand_off[k]};
    end

    pf_req_fifo #(.DEPTH(FIFO_DEPTH), .W(LINE_W+1)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!en),
        .push_v   (push_v),
        .push_d   (push_d),
        .pop      (pop),
        .nonempty (fifo_ne),
        .head     (fifo_head),
        .count    (fifo_cnt)
    );

    assign pf_line = fifo_head[LINE_W-1:0];
    assign pf_mlc  = fifo_head[LINE_W];
endmodule

// File: rtl/page_stream_prefetcher_chk.sv
module page_stream_prefetcher_chk
    import pf_stream_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 4,
    localparam int LINE_W    = ADDR_W - LINE_SH,
    localparam int CNT_W     = $clog2(FIFO_DEPTH+1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [LINE_W-1:0] pf_line,
    input logic              pf_mlc,
    input logic              acc_fire,
    input acc_cls_e          cls,
    input logic [1:0]        push_v,
    input logic [CNT_W-1:0]  fifo_cnt
);
    a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pf_valid);

    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && en) |=> (pf_valid && $stable(pf_line) && $stable(pf_mlc)));

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(FIFO_DEPTH));

    a_r2_new_page_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && cls == CLS_NEW) |-> (push_v == 2'b00));

    a_r6_same_line_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && cls == CLS_SAME) |-> (push_v == 2'b00));
endmodule

bind page_stream_prefetcher page_stream_prefetcher_chk #(
    .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pf_valid (pf_valid),
    .pf_ready (pf_ready),
    .pf_line  (pf_line),
    .pf_mlc   (pf_mlc),
    .acc_fire (acc_fire),
    .cls      (acc_cls),
    .push_v   (push_v),
    .fifo_cnt (fifo_cnt)
);

// File: tb/page_stream_prefetcher_tb.sv
`timescale 1ns/1ps
module page_stream_prefetcher_tb;
    localparam int LINE_W = 26;

    logic clk = 1'b0;
    logic rst_n, en, dmd_valid, mlc_busy, pf_ready;
    logic [LINE_W-1:0] dmd_line;
    logic pf_valid, pf_mlc;
    logic [LINE_W-1:0] pf_line;

    always #2.5 clk = ~clk;

    page_stream_prefetcher u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .dmd_valid(dmd_valid), .dmd_line(dmd_line),
        .mlc_busy(mlc_busy), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_line(pf_line), .pf_mlc(pf_mlc)
    );

    int nchk = 0, nerr = 0, iss = 0;
    bit last_mlc;
    string tag_s = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct { int last; bit fon; bit bon; int fedge; int bedge; } ms_t;
    typedef struct { int unsigned line; bit mlc; } req_t;
    int unsigned lru[$];
    ms_t tbl[int unsigned];
    req_t q[$];
    bit mrun = 0;

    task automatic model_access(input int unsigned ln, input bit busy, input int cnt0);
        int unsigned pg;
        int off, pos, reach, pushed;
        int c[2];
        bit v[2];
        ms_t e;
        req_t r;
        pg = ln >> 6;
        off = int'(ln & 63);
        pos = -1;
        pushed = 0;
        foreach (lru[i]) if (lru[i] == pg) pos = i;
        if (pos < 0) begin
            lru.push_front(pg);
            if (lru.size() > 16) begin
                tbl.delete(lru[16]);
                void'(lru.pop_back());
            end
            e.last = off; e.fon = 0; e.bon = 0; e.fedge = 0; e.bedge = 0;
            tbl[pg] = e;
            return;
        end
        lru.delete(pos);
        lru.push_front(pg);
        e = tbl[pg];
        v[0] = 0; v[1] = 0; c[0] = 0; c[1] = 0;
        if (off > e.last) begin
            c[0] = off + 1; c[1] = off + 2;
            v[0] = (c[0] <= 63) && (!e.fon || c[0] > e.fedge);
            v[1] = e.fon && (c[1] <= 63) && (c[1] > e.fedge);
            reach = e.fon ? c[1] : c[0];
            if (reach > 63) reach = 63;
            if (!(e.fon && e.fedge > reach)) e.fedge = reach;
            e.fon = 1;
        end else if (off < e.last) begin
            c[0] = off - 1; c[1] = off - 2;
            v[0] = (c[0] >= 0) && (!e.bon || c[0] < e.bedge);
            v[1] = e.bon && (c[1] >= 0) && (c[1] < e.bedge);
            reach = e.bon ? c[1] : c[0];
            if (reach < 0) reach = 0;
            if (!(e.bon && e.bedge < reach)) e.bedge = reach;
            e.bon = 1;
        end
        e.last = off;
        tbl[pg] = e;
        for (int k = 0; k < 2; k++) begin
            if (v[k] && (cnt0 + pushed < 4)) begin
                r.line = pg * 64 + c[k];
                r.mlc = !busy;
                q.push_back(r);
                pushed++;
            end
        end
    endtask

    always @(posedge clk) begin
        int cnt0;
        if (!rst_n) begin
            lru.delete(); tbl.delete(); q.delete(); mrun = 0;
        end else begin
            if (pf_valid && pf_ready) begin iss++; last_mlc = pf_mlc; end
            cnt0 = q.size();
            if (mrun && q.size() > 0 && pf_ready) void'(q.pop_front());
            if (!en) begin
                lru.delete(); tbl.delete(); q.delete();
            end else if (mrun && dmd_valid) begin
                model_access(dmd_line, mlc_busy, cnt0);
            end
            mrun = en;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        bit ev;
        if (rst_n) begin
            ev = mrun && (q.size() > 0);
            chk(pf_valid == ev, tag_s, "pf_valid", pf_valid, ev);
            if (ev && pf_valid) begin
                chk(pf_line == q[0].line, tag_s, "pf_line", pf_line, q[0].line);
                chk(pf_mlc == q[0].mlc, tag_s, "pf_mlc", pf_mlc, q[0].mlc);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic acc(input int pg, input int off, input bit busy);
        dmd_line  = LINE_W'(pg * 64 + off);
        dmd_valid = 1'b1;
        mlc_busy  = busy;
        @(negedge clk);
        dmd_valid = 1'b0;
        mlc_busy  = 1'b0;
    endtask

    task automatic restart();
        en = 1'b0; idle(2); en = 1'b1; idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst_n = 0; en = 0; dmd_valid = 0; dmd_line = '0; mlc_busy = 0; pf_ready = 1;
        idle(3);
        chk(pf_valid == 0, "R1", "pf_valid in reset", pf_valid, 0);
        rst_n = 1;
        idle(2);
        chk(pf_valid == 0, "R1", "pf_valid after reset", pf_valid, 0);
        en = 1; idle(2);

        tag_s = "R2"; iss = 0;
        acc(5, 10, 0); idle(4);
        chk(iss == 0, "R2", "requests on new page", iss, 0);

        tag_s = "R3"; iss = 0;
        acc(5, 11, 0);
        chk(pf_valid && pf_line == LINE_W'(5*64+12), "R12", "head right after trigger", pf_line, 5*64+12);
        idle(1);
        acc(5, 12, 0); idle(1);
        acc(5, 13, 0); idle(4);
        chk(iss == 4, "R3", "upward requests", iss, 4);
        chk(iss == 4, "R7", "no repeat of line 14", iss, 4);

        tag_s = "R4"; iss = 0;
        acc(7, 40, 0); idle(1);
        acc(7, 38, 0); idle(1);
        acc(7, 37, 0); idle(4);
        chk(iss == 3, "R4", "downward requests", iss, 3);

        tag_s = "R5"; iss = 0;
        acc(9, 60, 0); idle(1);
        acc(9, 62, 0); idle(1);
        acc(9, 63, 0); idle(1);
        acc(10, 3, 0); idle(1);
        acc(10, 1, 0); idle(1);
        acc(10, 0, 0); idle(4);
        chk(iss == 2, "R5", "requests at page edges", iss, 2);

        tag_s = "R6"; iss = 0;
        acc(9, 63, 0); idle(1);
        acc(5, 13, 0); idle(4);
        chk(iss == 0, "R6", "repeat line", iss, 0);

        tag_s = "R9"; iss = 0;
        acc(11, 0, 1); idle(1);
        acc(11, 1, 1); idle(3);
        chk(last_mlc == 0, "R9", "hint under load", last_mlc, 0);
        acc(11, 2, 0); idle(4);
        chk(last_mlc == 1, "R9", "hint when idle", last_mlc, 1);

        tag_s = "R10"; iss = 0; pf_ready = 0;
        acc(12, 0, 0); idle(1);
        acc(12, 1, 0); idle(1);
        acc(12, 2, 0); idle(1);
        acc(12, 10, 0); idle(1);
        acc(12, 20, 0); idle(2);
        chk(pf_valid && pf_line == LINE_W'(12*64+2), "R10", "head held while stalled", pf_line, 12*64+2);
        pf_ready = 1; idle(8);
        chk(iss == 4, "R10", "requests kept when full", iss, 4);

        tag_s = "R11"; iss = 0;
        acc(14, 5, 0); idle(1);
        acc(14, 6, 0);
        en = 0;
        idle(1);
        chk(pf_valid == 0, "R11", "pf_valid while disabled", pf_valid, 0);
        acc(14, 7, 0);
        en = 1; idle(2); iss = 0;
        acc(14, 8, 0); idle(4);
        chk(iss == 0, "R11", "table cleared by disable", iss, 0);

        tag_s = "R8"; restart(); iss = 0;
        for (int r = 0; r < 3; r++)
            for (int k = 0; k < 17; k++) begin
                acc(100 + (k * 5) % 17, (k * 3 + r * 7) % 50 + 5, 0);
                idle(1);
            end
        idle(4);
        chk(iss == 0, "R8", "17-page permutation", iss, 0);
        restart(); iss = 0;
        for (int r = 0; r < 2; r++)
            for (int k = 0; k < 16; k++) begin
                acc(200 + (k * 5) % 16, (k * 3 + r * 7) % 50 + 5, 0);
                idle(1);
            end
        idle(4);
        chk(iss == 16, "R8", "16-page permutation", iss, 16);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule